// File: doc/BRIEF.md
# Parallelism-Aware Batch Request Scheduler

This block picks the next request to hand to a shared DRAM command engine that serves several threads. Requests arrive with a thread number, a target bank, a row address and a read/write flag, and wait in a small slotted queue. The scheduler works in rounds called batches. When a batch starts, it marks the oldest few waiting requests of every thread to every bank. It also ranks the threads, and a thread with fewer marked requests is ranked higher. Marked requests are served before any later arrival, so no thread can be starved.

Inside a batch the pick is made in this order: marked before unmarked, then a hit on the bank's open row, then the higher-ranked thread, then the older request. Because one thread's requests outrank the other threads' requests, that thread's accesses to different banks issue back to back. Their bank latencies then overlap, so the thread waits about one bank access instead of two. A first-come-first-served mode can be selected instead. It ignores marks, hits and ranks, which gives a baseline for comparison.

A small state machine controls the batches. The states are IDLE (queue empty), FORM (one cycle that marks requests and ranks threads, with no grant) and SERVE (grants allowed). The transitions are:
- IDLE→FORM when a request is accepted.
- FORM→SERVE always.
- SERVE→SERVE while marked requests remain after this cycle.
- SERVE→FORM when the last marked request leaves and other requests remain.
- SERVE→IDLE when the queue drains.

Top module: `batch_req_sched`

## Requirements
- R1: After reset the queue is empty, the state is IDLE, `enq_ready` is 1 and `gnt_valid` is 0.
- R2: The queue holds NUM_ENTRIES requests. `enq_ready` is 0 exactly when every slot is full, and a request offered while `enq_ready` is 0 is dropped. An accepted request goes into the lowest-numbered free slot, and that slot number is later reported on `gnt_index`.
- R3: `gnt_valid` with `gnt_index` and the slot's thread, bank, row and write flag form the grant. The slot is freed in the cycle where `gnt_take` is 1. While `gnt_take` is 0 the request stays queued.
- R4: Only requests whose bank has `bank_ready` set are eligible. With no eligible request, `gnt_valid` is 0.
- R5: Batch formation follows the transitions above. It takes one FORM cycle, and no grant is issued in that cycle. Grants are issued only in SERVE.
- R6: At formation, for each thread and bank pair, the MARK_CAP oldest queued requests are marked. Requests that arrive later are unmarked until the next formation.
- R7: In batch mode a marked eligible request always wins over an unmarked one.
- R8: At equal mark status, a request whose row equals its bank's open row (with the bank's open-valid bit set) wins over one that does not.
- R9: Threads are ranked at formation. Fewer marked requests ranks higher, and equal counts are ordered by lower thread number. At equal mark and hit status the higher-ranked thread wins.
- R10: When all earlier criteria are equal, the request that arrived first wins.
- R11: With `fcfs_mode` at 1, the oldest eligible request is granted regardless of marks, hits and ranks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fcfs_mode | input | 1 | 1 selects first-come-first-served order |
| enq_valid | input | 1 | Request offered |
| enq_thread | input | TID_W | Thread number of offered request |
| enq_bank | input | BID_W | Target bank |
| enq_row | input | ROW_W | Target row |
| enq_write | input | 1 | 1 for write, 0 for read |
| enq_ready | output | 1 | Queue has a free slot |
| bank_ready | input | NUM_BANKS | Per-bank ready to accept a request |
| bank_open_valid | input | NUM_BANKS | Per-bank open row present |
| bank_open_row | input | NUM_BANKS*ROW_W | Per-bank open row, bank b at bits b*ROW_W upward |
| gnt_valid | output | 1 | A request is selected |
| gnt_take | input | 1 | Consumer accepts the selected request |
| gnt_index | output | IDX_W | Queue slot of the selected request |
| gnt_thread | output | TID_W | Thread of the selected request |
| gnt_bank | output | BID_W | Bank of the selected request |
| gnt_row | output | ROW_W | Row of the selected request |
| gnt_write | output | 1 | Write flag of the selected request |

## Verification
A wrong mark bit or thread rank does not show up as a bad signal value. It shows up as a different winner on `gnt_index`. The first such grant in SERVE, where two candidates differ only in mark or rank, exposes it. A corrupted age order shows up as a different winner between otherwise equal requests on the next grant. A wrong state transition shows up one cycle after the fault, either as a grant during what should be a FORM cycle or as a missing grant. The bench therefore predicts `gnt_valid`, `gnt_index`, the granted fields and `enq_ready` on every clock, using a behavioural model of the queue. Any divergence is reported on the cycle where it first reaches the ports.

// File: rtl/psched_pkg.sv
package psched_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FORM  = 2'd1,
        ST_SERVE = 2'd2
    } sched_state_e;
endpackage

// File: rtl/psched_queue.sv
module psched_queue #(
    parameter int NUM_ENTRIES = 8,
    parameter int TID_W = 2,
    parameter int BID_W = 2,
    parameter int ROW_W = 8,
    parameter int IDX_W = 3
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                enq_fire,
    input  logic [TID_W-1:0]                    enq_thread,
    input  logic [BID_W-1:0]                    enq_bank,
    input  logic [ROW_W-1:0]                    enq_row,
    input  logic                                enq_write,
    input  logic                                deq_fire,
    input  logic [IDX_W-1:0]                    deq_idx,
    input  logic                                load_marks,
    input  logic [NUM_ENTRIES-1:0]              mark_in,
    output logic [NUM_ENTRIES-1:0]              q_valid,
    output logic [NUM_ENTRIES-1:0]              q_marked,
    output logic [NUM_ENTRIES-1:0][TID_W-1:0]   q_thread,
    output logic [NUM_ENTRIES-1:0][BID_W-1:0]   q_bank,
    output logic [NUM_ENTRIES-1:0][ROW_W-1:0]   q_row,
    output logic [NUM_ENTRIES-1:0]              q_write,
    output logic [NUM_ENTRIES-1:0][IDX_W-1:0]   q_age,
    output logic                                full,
    output logic [IDX_W-1:0]                    free_idx
);
    // lowest free slot receives the next arrival
    always_comb begin
        free_idx = '0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (!q_valid[i]) free_idx = IDX_W'(i);
        end
    end

    assign full = &q_valid;

    // q_age counts the younger live entries, so ages stay a permutation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_valid  <= '0;
            q_marked <= '0;
            q_age    <= '0;
            q_thread <= '0;
            q_bank   <= '0;
            q_row    <= '0;
            q_write  <= '0;
        end else begin
            for (int i = 0; i < NUM_ENTRIES; i++) begin
                if (deq_fire && deq_idx == IDX_W'(i)) begin
                    q_valid[i]  <= 1'b0;
                    q_marked[i] <= 1'b0;
                end else if (enq_fire && free_idx == IDX_W'(i)) begin
                    q_valid[i]  <= 1'b1;
                    q_marked[i] <= 1'b0;
                    q_age[i]    <= '0;
                    q_thread[i] <= enq_thread;
                    q_bank[i]   <= enq_bank;
                    q_row[i]    <= enq_row;
                    q_write[i]  <= enq_write;
                end else if (q_valid[i]) begin
                    q_age[i] <= q_age[i] + IDX_W'(enq_fire)
                              - IDX_W'(deq_fire && (q_age[i] > q_age[deq_idx]));
                    if (load_marks) q_marked[i] <= mark_in[i];
                end
            end
        end
    end

    assert_no_enq_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !enq_fire);

    assert_deq_frees_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        deq_fire |=> !q_valid[$past(deq_idx)]);
endmodule

// File: rtl/psched_batcher.sv
module psched_batcher #(
    parameter int NUM_ENTRIES = 8,
    parameter int NUM_THREADS = 4,
    parameter int TID_W = 2,
    parameter int BID_W = 2,
    parameter int IDX_W = 3,
    parameter int RANK_W = 2,
    parameter int MARK_CAP = 2
) (
    input  logic [NUM_ENTRIES-1:0]             q_valid,
    input  logic [NUM_ENTRIES-1:0][TID_W-1:0]  q_thread,
    input  logic [NUM_ENTRIES-1:0][BID_W-1:0]  q_bank,
    input  logic [NUM_ENTRIES-1:0][IDX_W-1:0]  q_age,
    output logic [NUM_ENTRIES-1:0]             mark_out,
    output logic [NUM_THREADS-1:0][RANK_W-1:0] rank_out
);
    int older_cnt [NUM_ENTRIES];
    int thr_marks [NUM_THREADS];
    int thr_rank  [NUM_THREADS];

    // an entry is marked when fewer than MARK_CAP older peers share its thread and bank
    always_comb begin
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            older_cnt[i] = 0;
            for (int j = 0; j < NUM_ENTRIES; j++) begin
                if (j != i && q_valid[j] && q_thread[j] == q_thread[i] &&
                    q_bank[j] == q_bank[i] && q_age[j] > q_age[i])
                    older_cnt[i] = older_cnt[i] + 1;
            end
            mark_out[i] = q_valid[i] && (older_cnt[i] < MARK_CAP);
        end
    end

    // rank 0 is best: fewest marks, then lowest thread number
    always_comb begin
        for (int t = 0; t < NUM_THREADS; t++) begin
            thr_marks[t] = 0;
            for (int i = 0; i < NUM_ENTRIES; i++) begin
                if (mark_out[i] && q_thread[i] == TID_W'(t))
                    thr_marks[t] = thr_marks[t] + 1;
            end
        end
        for (int t = 0; t < NUM_THREADS; t++) begin
            thr_rank[t] = 0;
            for (int u = 0; u < NUM_THREADS; u++) begin
                if (thr_marks[u] < thr_marks[t] || (thr_marks[u] == thr_marks[t] && u < t))
                    thr_rank[t] = thr_rank[t] + 1;
            end
            rank_out[t] = RANK_W'(thr_rank[t]);
        end
    end
endmodule

// File: rtl/psched_picker.sv
module psched_picker #(
    parameter int NUM_ENTRIES = 8,
    parameter int NUM_THREADS = 4,
    parameter int NUM_BANKS = 4,
    parameter int TID_W = 2,
    parameter int BID_W = 2,
    parameter int ROW_W = 8,
    parameter int IDX_W = 3,
    parameter int RANK_W = 2
) (
    input  logic                               fcfs,
    input  logic [NUM_ENTRIES-1:0]             q_valid,
    input  logic [NUM_ENTRIES-1:0]             q_marked,
    input  logic [NUM_ENTRIES-1:0][TID_W-1:0]  q_thread,
    input  logic [NUM_ENTRIES-1:0][BID_W-1:0]  q_bank,
    input  logic [NUM_ENTRIES-1:0][ROW_W-1:0]  q_row,
    input  logic [NUM_ENTRIES-1:0][IDX_W-1:0]  q_age,
    input  logic [NUM_THREADS-1:0][RANK_W-1:0] rank_in,
    input  logic [NUM_BANKS-1:0]               bank_ready,
    input  logic [NUM_BANKS-1:0]               open_valid,
    input  logic [NUM_BANKS*ROW_W-1:0]         open_row,
    output logic                               pick_any,
    output logic [IDX_W-1:0]                   pick_idx
);
    localparam int KEY_W = 2 + RANK_W + IDX_W;

    logic [NUM_ENTRIES-1:0]            hit_v;
    logic [NUM_ENTRIES-1:0]            elig_v;
    logic [NUM_ENTRIES-1:0][KEY_W-1:0] key_v;
    logic [KEY_W-1:0]                  best_key;

    // priority key, most significant first: mark, row hit, inverted rank, age
    always_comb begin
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            hit_v[i]  = open_valid[q_bank[i]] &&
                        (open_row[q_bank[i]*ROW_W +: ROW_W] == q_row[i]);
            elig_v[i] = q_valid[i] && bank_ready[q_bank[i]];
            key_v[i]  = fcfs ? KEY_W'(q_age[i])
                             : {q_marked[i], hit_v[i], ~rank_in[q_thread[i]], q_age[i]};
        end
    end

    always_comb begin
        pick_any = 1'b0;
        pick_idx = '0;
        best_key = '0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (elig_v[i] && (!pick_any || key_v[i] > best_key)) begin
                pick_any = 1'b1;
                pick_idx = IDX_W'(i);
                best_key = key_v[i];
            end
        end
    end
endmodule

// File: rtl/batch_req_sched.sv
module batch_req_sched
    import psched_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    parameter int NUM_THREADS = 4,
    parameter int NUM_BANKS = 4,
    parameter int ROW_W = 8,
    parameter int MARK_CAP = 2,
    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
    localparam int TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
    localparam int BID_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int RANK_W = TID_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       fcfs_mode,
    input  logic                       enq_valid,
    input  logic [TID_W-1:0]           enq_thread,
    input  logic [BID_W-1:0]           enq_bank,
    input  logic [ROW_W-1:0]           enq_row,
    input  logic                       enq_write,
    output logic                       enq_ready,
    input  logic [NUM_BANKS-1:0]       bank_ready,
    input  logic [NUM_BANKS-1:0]       bank_open_valid,
    input  logic [NUM_BANKS*ROW_W-1:0] bank_open_row,
    output logic                       gnt_valid,
    input  logic                       gnt_take,
    output logic [IDX_W-1:0]           gnt_index,
    output logic [TID_W-1:0]           gnt_thread,
    output logic [BID_W-1:0]           gnt_bank,
    output logic [ROW_W-1:0]           gnt_row,
    output logic                       gnt_write
);
    sched_state_e state_q, state_d;

    logic [NUM_ENTRIES-1:0]             q_valid, q_marked, q_write, mark_w, deq_oh;
    logic [NUM_ENTRIES-1:0][TID_W-1:0]  q_thread;
    logic [NUM_ENTRIES-1:0][BID_W-1:0]  q_bank;
    logic [NUM_ENTRIES-1:0][ROW_W-1:0]  q_row;
    logic [NUM_ENTRIES-1:0][IDX_W-1:0]  q_age;
    logic [NUM_THREADS-1:0][RANK_W-1:0] rank_w, rank_q;
    logic                               full, enq_fire, deq_fire, pick_any;
    logic                               marks_left, entries_left;
    logic [IDX_W-1:0]                   free_idx, pick_idx;

    assign enq_fire = enq_valid && !full;
    assign deq_fire = gnt_valid && gnt_take;
    assign deq_oh   = deq_fire ? (NUM_ENTRIES'(1) << gnt_index) : '0;

    psched_queue #(
        .NUM_ENTRIES(NUM_ENTRIES), .TID_W(TID_W), .BID_W(BID_W),
        .ROW_W(ROW_W), .IDX_W(IDX_W)
    ) queue_i (
        .clk(clk), .rst_n(rst_n),
        .enq_fire(enq_fire), .enq_thread(enq_thread), .enq_bank(enq_bank),
        .enq_row(enq_row), .enq_write(enq_write),
        .deq_fire(deq_fire), .deq_idx(gnt_index),
        .load_marks(state_q == ST_FORM), .mark_in(mark_w),
        .q_valid(q_valid), .q_marked(q_marked), .q_thread(q_thread),
        .q_bank(q_bank), .q_row(q_row), .q_write(q_write), .q_age(q_age),
        .full(full), .free_idx(free_idx)
    );

    psched_batcher #(
        .NUM_ENTRIES(NUM_ENTRIES), .NUM_THREADS(NUM_THREADS), .TID_W(TID_W),
        .BID_W(BID_W), .IDX_W(IDX_W), .RANK_W(RANK_W), .MARK_CAP(MARK_CAP)
    ) batcher_i (
        .q_valid(q_valid), .q_thread(q_thread), .q_bank(q_bank), .q_age(q_age),
        .mark_out(mark_w), .rank_out(rank_w)
    );

    psched_picker #(
        .NUM_ENTRIES(NUM_ENTRIES), .NUM_THREADS(NUM_THREADS), .NUM_BANKS(NUM_BANKS),
        .TID_W(TID_W), .BID_W(BID_W), .ROW_W(ROW_W), .IDX_W(IDX_W), .RANK_W(RANK_W)
    ) picker_i (
        .fcfs(fcfs_mode), .q_valid(q_valid), .q_marked(q_marked),
        .q_thread(q_thread), .q_bank(q_bank), .q_row(q_row), .q_age(q_age),
        .rank_in(rank_q), .bank_ready(bank_ready), .open_valid(bank_open_valid),
        .open_row(bank_open_row), .pick_any(pick_any), .pick_idx(pick_idx)
    );

    assign marks_left   = |(q_valid & q_marked & ~deq_oh);
    assign entries_left = (|(q_valid & ~deq_oh)) || enq_fire;

    always_comb begin
        unique case (state_q)
            ST_IDLE:  state_d = enq_fire ? ST_FORM : ST_IDLE;
            ST_FORM:  state_d = ST_SERVE;
            ST_SERVE: state_d = marks_left   ? ST_SERVE :
                                entries_left ? ST_FORM  : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register, with thread ranks captured at formation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rank_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_FORM) rank_q <= rank_w;
        end
    end

    // outputs
    always_comb begin
        enq_ready  = !full;
        gnt_valid  = (state_q == ST_SERVE) && pick_any;
        gnt_index  = pick_idx;
        gnt_thread = q_thread[pick_idx];
        gnt_bank   = q_bank[pick_idx];
        gnt_row    = q_row[pick_idx];
        gnt_write  = q_write[pick_idx];
    end

    assert_idle_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (q_valid == '0));

    assert_grant_bank_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> bank_ready[gnt_bank]);

    assert_form_leaves_marks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FORM) |=> (|(q_valid & q_marked)));

    assert_grant_slot_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> q_valid[gnt_index]);
endmodule

// File: tb/batch_req_sched_tb_top.sv
module batch_req_sched_tb_top;
    localparam int N = 8, NT = 4, NB = 4, RW = 8, CAP = 2;
    localparam int IW = 3, TW = 2, BW = 2;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n, fcfs_mode, enq_valid, enq_write, enq_ready;
    logic [TW-1:0] enq_thread;
    logic [BW-1:0] enq_bank;
    logic [RW-1:0] enq_row;
    logic [NB-1:0] bank_ready, bank_open_valid;
    logic [NB*RW-1:0] bank_open_row;
    logic gnt_valid, gnt_take, gnt_write;
    logic [IW-1:0] gnt_index;
    logic [TW-1:0] gnt_thread;
    logic [BW-1:0] gnt_bank;
    logic [RW-1:0] gnt_row;

    batch_req_sched #(.NUM_ENTRIES(N), .NUM_THREADS(NT), .NUM_BANKS(NB),
                      .ROW_W(RW), .MARK_CAP(CAP)) dut_i (
        .clk(clk), .rst_n(rst_n), .fcfs_mode(fcfs_mode),
        .enq_valid(enq_valid), .enq_thread(enq_thread), .enq_bank(enq_bank),
        .enq_row(enq_row), .enq_write(enq_write), .enq_ready(enq_ready),
        .bank_ready(bank_ready), .bank_open_valid(bank_open_valid),
        .bank_open_row(bank_open_row), .gnt_valid(gnt_valid), .gnt_take(gnt_take),
        .gnt_index(gnt_index), .gnt_thread(gnt_thread), .gnt_bank(gnt_bank),
        .gnt_row(gnt_row), .gnt_write(gnt_write)
    );

    int checks = 0, fails = 0;
    string cur_req = "R1";

    // behavioural model: slots plus an arrival-ordered list
    bit mv [N];
    bit mm [N];
    bit mw [N];
    int mt [N], mb [N], mr [N];
    int mrank [NT];
    int ord [$];
    int mst = 0; // 0 idle, 1 form, 2 serve

    task automatic chk(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", cur_req, what, act, exp);
        end
    endtask

    function automatic bit is_hit(int s);
        return bank_open_valid[mb[s]] && (int'(bank_open_row[mb[s]*RW +: RW]) == mr[s]);
    endfunction

    function automatic bit beats(int a, int b);
        if (mm[a] != mm[b]) return mm[a];
        if (is_hit(a) != is_hit(b)) return is_hit(a);
        if (mrank[mt[a]] != mrank[mt[b]]) return mrank[mt[a]] < mrank[mt[b]];
        return 1'b0;
    endfunction

    task automatic cycle();
        bit exp_gv, exp_er, fe, fg, left;
        int exp_idx, free_s, pos;
        int gcnt [NT][NB];
        int mc [NT];
        #1;
        exp_er = ord.size() < N;
        exp_gv = 1'b0;
        exp_idx = 0;
        if (mst == 2) begin
            foreach (ord[k]) begin
                if (bank_ready[mb[ord[k]]]) begin
                    if (!exp_gv) begin
                        exp_gv = 1'b1;
                        exp_idx = ord[k];
                    end else if (!fcfs_mode && beats(ord[k], exp_idx)) begin
                        exp_idx = ord[k];
                    end
                end
            end
        end
        chk("enq_ready", int'(enq_ready), int'(exp_er));
        chk("gnt_valid", int'(gnt_valid), int'(exp_gv));
        if (exp_gv && gnt_valid) begin
            chk("gnt_index", int'(gnt_index), exp_idx);
            chk("gnt_thread", int'(gnt_thread), mt[exp_idx]);
            chk("gnt_bank", int'(gnt_bank), mb[exp_idx]);
            chk("gnt_row", int'(gnt_row), mr[exp_idx]);
            chk("gnt_write", int'(gnt_write), int'(mw[exp_idx]));
        end
        @(posedge clk);
        if (mst == 1) begin
            foreach (gcnt[t, b]) gcnt[t][b] = 0;
            foreach (mc[t]) mc[t] = 0;
            foreach (ord[k]) begin
                mm[ord[k]] = gcnt[mt[ord[k]]][mb[ord[k]]] < CAP;
                gcnt[mt[ord[k]]][mb[ord[k]]]++;
                if (mm[ord[k]]) mc[mt[ord[k]]]++;
            end
            for (int t = 0; t < NT; t++) begin
                mrank[t] = 0;
                for (int u = 0; u < NT; u++)
                    if (mc[u] < mc[t] || (mc[u] == mc[t] && u < t)) mrank[t]++;
            end
        end
        fe = enq_valid && exp_er;
        fg = exp_gv && gnt_take;
        free_s = 0;
        for (int s = N - 1; s >= 0; s--) if (!mv[s]) free_s = s;
        if (fg) begin
            mv[exp_idx] = 1'b0;
            mm[exp_idx] = 1'b0;
            pos = 0;
            foreach (ord[k]) if (ord[k] == exp_idx) pos = k;
            ord.delete(pos);
        end
        if (fe) begin
            mv[free_s] = 1'b1; mm[free_s] = 1'b0;
            mt[free_s] = int'(enq_thread); mb[free_s] = int'(enq_bank);
            mr[free_s] = int'(enq_row); mw[free_s] = enq_write;
            ord.push_back(free_s);
        end
        left = 1'b0;
        foreach (ord[k]) if (mm[ord[k]]) left = 1'b1;
        case (mst)
            0: if (fe) mst = 1;
            1: mst = 2;
            default: mst = left ? 2 : (ord.size() > 0 ? 1 : 0);
        endcase
        @(negedge clk);
    endtask

    task automatic phase(string req, int n, int p_enq, int p_take, int p_rdy,
                         int rows, bit fcfs, int nthr);
        cur_req = req;
        fcfs_mode = fcfs;
        for (int c = 0; c < n; c++) begin
            enq_valid  = $urandom_range(99) < p_enq;
            enq_thread = TW'($urandom_range(nthr - 1));
            enq_bank   = BW'($urandom_range(NB - 1));
            enq_row    = RW'($urandom_range(rows - 1));
            enq_write  = 1'($urandom_range(1));
            gnt_take   = $urandom_range(99) < p_take;
            for (int b = 0; b < NB; b++) begin
                bank_ready[b] = $urandom_range(99) < p_rdy;
                bank_open_valid[b] = 1'($urandom_range(1));
                bank_open_row[b*RW +: RW] = RW'($urandom_range(rows - 1));
            end
            cycle();
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; fcfs_mode = 1'b0; enq_valid = 1'b0; enq_thread = '0;
        enq_bank = '0; enq_row = '0; enq_write = 1'b0; gnt_take = 1'b0;
        bank_ready = '0; bank_open_valid = '0; bank_open_row = '0;
        for (int s = 0; s < N; s++) begin mv[s] = 0; mm[s] = 0; end
        for (int t = 0; t < NT; t++) mrank[t] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, nothing offered
        phase("R1", 2, 0, 0, 100, 4, 1'b0, NT);
        // R2: fill with all banks busy, then keep offering while full
        phase("R2", 14, 100, 0, 0, 4, 1'b0, NT);
        // R3: drain, then grants held back by gnt_take
        phase("R3", 20, 0, 100, 100, 4, 1'b0, NT);
        phase("R3", 300, 50, 35, 80, 4, 1'b0, NT);
        // R4: sparse bank readiness
        phase("R4", 300, 60, 100, 25, 4, 1'b0, NT);
        // R5: bursts across batch boundaries
        phase("R5", 300, 40, 90, 90, 4, 1'b0, NT);
        // R6 and R7: two threads crowding the same banks
        phase("R6", 400, 80, 60, 70, 4, 1'b0, 2);
        phase("R7", 400, 90, 50, 60, 4, 1'b0, NT);
        // R8: few distinct rows so hits are frequent
        phase("R8", 400, 70, 70, 80, 2, 1'b0, NT);
        // R9: thread ranking with uneven load
        phase("R9", 400, 85, 60, 90, 8, 1'b0, NT);
        // R10: single row everywhere, age decides most ties
        phase("R10", 300, 70, 70, 90, 1, 1'b0, NT);
        // R11: baseline arrival order
        phase("R11", 400, 70, 70, 70, 4, 1'b1, NT);
        phase("R11", 20, 0, 100, 100, 4, 1'b1, NT);
        summary();
        $finish;
    end
endmodule